// File: doc/BRIEF.md
# Read Request Packet Generator

This block turns one read request, presented as a set of parallel fields, into a fixed five-word outbound packet carried on a 32-bit valid/ready stream. The requesting logic raises a request line and holds the fields steady. The block then emits the header words one per accepted beat. After the last beat it raises a done flag, which stays up until the requester lowers its request line. The packet carries no payload. The acknowledge-ID field and the 16-bit check slot are sent as zero so that a later link stage can fill them in.

Back-pressure rules on the stream are as follows. A beat transfers on a rising edge where both `pkt_valid` and `pkt_ready` are high. While `pkt_valid` is high and `pkt_ready` is low, the block holds `pkt_valid` high and does not advance to the next word. `pkt_data` also stays unchanged, provided the request fields are held, which is the requester's duty. `pkt_valid` is low whenever no packet is being sent. The word sent on each beat depends only on the beat's position in the packet, so stalls of any length or pattern produce the same packet.

Top module: `rdreq_gen`

## Requirements
- R1: While `rst_n` is low and on the first edges after its release with `rq_pend` low, `pkt_valid` and `rq_done` are both low.
- R2: The edge that sees `rq_pend` high while idle makes `pkt_valid` go high. The first beat then carries bits 31:16 = 0, bits 15:10 = 0, bit 9 = `rq_vc`, bit 8 = `rq_crf`, bits 7:6 = `rq_prio`, bits 5:4 = `rq_tt`, and bits 3:0 = 4'h2.
- R3: The second beat carries `rq_dst` and the third beat carries `rq_src`, each as all 32 bits.
- R4: The fourth beat carries bits 31:28 = 4'h4 (the read code), bits 27:24 = `rq_size`, bits 23:16 = `rq_tid`, and bits 15:0 = `rq_addr[28:13]`.
- R5: The fifth beat carries bits 31:19 = `rq_addr[12:0]`, bit 18 = `rq_wptr`, bits 17:16 = `rq_addr[30:29]`, and bits 15:0 = 0.
- R6: During a cycle with `pkt_valid` high and `pkt_ready` low, the next cycle still has `pkt_valid` high and shows the same `pkt_data`.
- R7: Exactly five beats transfer per request. After the fifth beat, `pkt_valid` is low.
- R8: `rq_done` rises on the edge that accepts the fifth beat. It stays high while `rq_pend` stays high and falls on the first edge that sees `rq_pend` low. `rq_done` and `pkt_valid` are never high together.
- R9: After `rq_done` falls, a new request starts again at the first beat, with fresh field values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rq_pend | input | 1 | Request pending; the fields are held while it is high |
| rq_vc | input | 1 | Virtual channel bit |
| rq_crf | input | 1 | Critical-request flag |
| rq_prio | input | 2 | Priority |
| rq_tt | input | 2 | Transport type |
| rq_dst | input | 32 | Destination ID |
| rq_src | input | 32 | Source ID |
| rq_tid | input | 8 | Transaction ID |
| rq_addr | input | 31 | Double-word address |
| rq_size | input | 4 | Read size code |
| rq_wptr | input | 1 | Word pointer |
| rq_done | output | 1 | Packet fully sent; held until `rq_pend` falls |
| pkt_valid | output | 1 | Stream word valid |
| pkt_data | output | 32 | Stream word |
| pkt_ready | input | 1 | Downstream can accept the word |

## Verification
Two events can land on the same edge: acceptance of the last word, and the move into the completion state. Both can also coincide with a stall that ends just as the last word is offered. The bench sweeps every size code with both word-pointer values. It drives `pkt_ready` through several phase-shifted stall patterns, so the final beat is accepted either right away or after a number of stalled cycles. On the sampling point that follows the accepting edge, the bench expects `rq_done` high and `pkt_valid` low. It then checks that `rq_done` holds while the request stays up and drops one edge after the request falls.

// File: rtl/rdreq_pkg.sv
package rdreq_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 5;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  localparam logic [3:0] FMT_REQUEST = 4'h2;
  localparam logic [3:0] TXN_READ    = 4'h4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rdreq_seq.sv
module rdreq_seq
  import rdreq_pkg::*;
#(
  parameter int N_WORDS = NUM_WORDS,
  localparam int IW = $clog2(N_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic          done_o,
  output logic [IW-1:0] idx_o
);
  localparam logic [IW-1:0] LAST = IW'(N_WORDS - 1);

  seq_state_e    state_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          idx_q <= '0;
          if (start_i) state_q <= ST_SEND;
        end
        ST_SEND: begin
          if (ready_i) begin
            if (idx_q == LAST) state_q <= ST_DONE;
            else               idx_q   <= idx_q + 1'b1;
          end
        end
        ST_DONE: begin
          if (!start_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign valid_o = (state_q == ST_SEND);
  assign done_o  = (state_q == ST_DONE);
  assign idx_o   = idx_q;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(idx_o)));

  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (idx_o <= LAST));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> done_o);
endmodule

// File: rtl/rdreq_word_mux.sv
module rdreq_word_mux
  import rdreq_pkg::*;
#(
  parameter int ADDR_W = 31,
  parameter int ID_W   = 32,
  localparam int HI_LSB = 13,
  localparam int TOP_LSB = ADDR_W - 2
) (
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              vc_i,
  input  logic              crf_i,
  input  logic [1:0]        prio_i,
  input  logic [1:0]        tt_i,
  input  logic [ID_W-1:0]   dst_i,
  input  logic [ID_W-1:0]   src_i,
  input  logic [7:0]        tid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        size_i,
  input  logic              wptr_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] words [NUM_WORDS];

  // header word: ack slot left zero for the link stage
  assign words[0] = {16'h0000, 6'd0, vc_i, crf_i, prio_i, tt_i, FMT_REQUEST};
  assign words[1] = dst_i;
  assign words[2] = src_i;
  // upper address chunk follows the code / size / id bytes
  assign words[3] = {TXN_READ, size_i, tid_i, addr_i[TOP_LSB-1:HI_LSB]};
  // lower address chunk sits beside the pointer and the extra MSBs
  assign words[4] = {addr_i[HI_LSB-1:0], wptr_i, addr_i[ADDR_W-1:TOP_LSB], 16'h0000};

  always_comb begin
    word_o = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (idx_i == IDX_W'(i)) word_o = words[i];
    end
  end
endmodule

// File: rtl/rdreq_gen.sv
module rdreq_gen
  import rdreq_pkg::*;
#(
  parameter int ADDR_W = 31,
  parameter int ID_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rq_pend,
  input  logic              rq_vc,
  input  logic              rq_crf,
  input  logic [1:0]        rq_prio,
  input  logic [1:0]        rq_tt,
  input  logic [ID_W-1:0]   rq_dst,
  input  logic [ID_W-1:0]   rq_src,
  input  logic [7:0]        rq_tid,
  input  logic [ADDR_W-1:0] rq_addr,
  input  logic [3:0]        rq_size,
  input  logic              rq_wptr,
  output logic              rq_done,
  output logic              pkt_valid,
  output logic [WORD_W-1:0] pkt_data,
  input  logic              pkt_ready
);
  logic [IDX_W-1:0] beat_idx;

  rdreq_seq #(.N_WORDS(NUM_WORDS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (rq_pend),
    .ready_i (pkt_ready),
    .valid_o (pkt_valid),
    .done_o  (rq_done),
    .idx_o   (beat_idx)
  );

  rdreq_word_mux #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_mux (
    .idx_i  (beat_idx),
    .vc_i   (rq_vc),
    .crf_i  (rq_crf),
    .prio_i (rq_prio),
    .tt_i   (rq_tt),
    .dst_i  (rq_dst),
    .src_i  (rq_src),
    .tid_i  (rq_tid),
    .addr_i (rq_addr),
    .size_i (rq_size),
    .wptr_i (rq_wptr),
    .word_o (pkt_data)
  );

  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rq_done && pkt_valid));

  // R6
  valid_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> pkt_valid);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_valid && !rq_done && rq_pend) |=> pkt_valid);
endmodule

// File: tb/rdreq_gen_bench.sv
module rdreq_gen_bench;
  localparam time HALF = 2.5ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rq_pend = 1'b0;
  logic        rq_vc = 1'b0, rq_crf = 1'b0, rq_wptr = 1'b0;
  logic [1:0]  rq_prio = '0, rq_tt = '0;
  logic [31:0] rq_dst = '0, rq_src = '0;
  logic [7:0]  rq_tid = '0;
  logic [30:0] rq_addr = '0;
  logic [3:0]  rq_size = '0;
  logic        rq_done, pkt_valid, pkt_ready = 1'b0;
  logic [31:0] pkt_data;

  int n_chk = 0, n_bad = 0;

  always #HALF clk = ~clk;

  rdreq_gen u_rdreq_gen (
    .clk(clk), .rst_n(rst_n), .rq_pend(rq_pend), .rq_vc(rq_vc), .rq_crf(rq_crf),
    .rq_prio(rq_prio), .rq_tt(rq_tt), .rq_dst(rq_dst), .rq_src(rq_src),
    .rq_tid(rq_tid), .rq_addr(rq_addr), .rq_size(rq_size), .rq_wptr(rq_wptr),
    .rq_done(rq_done), .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_ready(pkt_ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input int b);
    case (b)
      0: exp_word = {16'h0, 6'd0, rq_vc, rq_crf, rq_prio, rq_tt, 4'h2};
      1: exp_word = rq_dst;
      2: exp_word = rq_src;
      3: exp_word = {4'h4, rq_size, rq_tid, rq_addr[28:13]};
      default: exp_word = {rq_addr[12:0], rq_wptr, rq_addr[30:29], 16'h0};
    endcase
  endfunction

  task automatic run_pkt(input int p, input int mode);
    int beat = 0;
    int cyc = 0;
    logic pv = 1'b0, pr = 1'b0;
    logic [31:0] pd = '0;
    rq_vc = p[0]; rq_crf = p[1]; rq_prio = 2'(p * 3); rq_tt = 2'(p >> 2);
    rq_dst = 32'hD000_0000 ^ (p * 32'h0101_0301);
    rq_src = 32'h5A00_0000 + p * 32'h0003_0077;
    rq_tid = 8'(p * 37 + 5);
    rq_addr = 31'(32'h6B4F_1C35 * (p + 1));
    rq_size = 4'(p >> 1); rq_wptr = p[0] ^ p[4];
    rq_pend = 1'b1;
    @(negedge clk);
    // R2: valid follows the request edge
    check("R2 valid", {31'd0, pkt_valid}, 32'd1);
    while (beat < 5 && cyc < 200) begin
      case (mode)
        0: pkt_ready = 1'b1;
        1: pkt_ready = ((cyc + p) % 3) != 0;
        2: pkt_ready = ((cyc * 7 + p) % 5) == 4;
        default: pkt_ready = (cyc % 2) == 1;
      endcase
      if (pv && !pr) begin
        // R6: stalled word held
        check("R6 hold valid", {31'd0, pkt_valid}, 32'd1);
        check("R6 hold data", pkt_data, pd);
      end
      if (pkt_valid && pkt_ready) begin
        case (beat)
          0: check("R2 word0", pkt_data, exp_word(0));
          1: check("R3 dst", pkt_data, exp_word(1));
          2: check("R3 src", pkt_data, exp_word(2));
          3: check("R4 word3", pkt_data, exp_word(3));
          default: check("R5 word4", pkt_data, exp_word(4));
        endcase
        beat++;
      end
      pv = pkt_valid; pr = pkt_ready; pd = pkt_data;
      cyc++;
      @(negedge clk);
    end
    if (cyc >= 200) check("R7 beats", beat, 5);
    pkt_ready = 1'b0;
    // R7 / R8: after last beat valid low and done high
    check("R7 valid after last", {31'd0, pkt_valid}, 32'd0);
    check("R8 done rise", {31'd0, rq_done}, 32'd1);
    pkt_ready = 1'b1;
    @(negedge clk);
    check("R8 done held", {31'd0, rq_done}, 32'd1);
    check("R7 no extra beat", {31'd0, pkt_valid}, 32'd0);
    rq_pend = 1'b0;
    @(negedge clk);
    check("R8 done fall", {31'd0, rq_done}, 32'd0);
    check("R8 valid idle", {31'd0, pkt_valid}, 32'd0);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid in reset", {31'd0, pkt_valid}, 32'd0);
    check("R1 done in reset", {31'd0, rq_done}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 valid idle", {31'd0, pkt_valid}, 32'd0);
    check("R1 done idle", {31'd0, rq_done}, 32'd0);
    // R9: back-to-back requests sweep all size codes, both pointers, four stall patterns
    for (int p = 0; p < 32; p++) begin
      for (int m = 0; m < 4; m++) begin
        run_pkt(p * 4 + m, m);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule